// File: doc/BRIEF.md
# Planar Hardware Cursor Overlay

This block overlays a 64x64 two-plane cursor image on a pixel stream in a palette DAC front end. Software programs it through a byte-wide register port with a small address input. Two data ports step their own pointers automatically. One is an image port that streams bytes into cursor storage. The other is a colour port that takes red, green and blue bytes for each cursor colour in turn. A further control register can only be reached through an unlock sequence. When it is unlocked, it takes the place of a read-only status register at the same address.

For every raster position (pixel x, y and a valid strobe) the block reports whether the cursor covers that pixel. It also gives a 2-bit colour select and the 24-bit colour picked from the cursor palette. The programmed position carries a bias of 64 on each axis, so the cursor origin can sit partly above or left of the visible area. A large Y value parks the cursor below any practical raster.

Top module: `hwcur_overlay`

## Requirements
- R1: After reset every register reads 0, the cursor is disabled, and ovl_valid, ovl_sel and ovl_rgb are 0.
- R2: Addresses 8, 9, 10 and 11 hold X low, X high, Y low and Y high. The high registers keep only their low POS_W-8 bits (4 by default), and the rest read back as 0.
- R3: The cursor origin is the programmed position minus 64 on each axis. A pixel lies inside the window when origin <= pixel < origin + size on both axes, so a position of (64,64) puts image pixel (0,0) at screen (0,0).
- R4: A write to address 1 loads the image pointer with the written byte. Each write to address 2 stores a byte at the pointer and then steps the pointer by one, wrapping from 1023 to 0. Bytes 0..511 form plane A and bytes 512..1023 form plane B. Byte row*8+col/8 holds the pixel in bit 7-(col%8). Reading address 1 returns pointer bits 7:0. The status register returns pointer bits 9:8.
- R5: For a covered pixel the select is {plane A bit, plane B bit}: 00 is transparent, 01 selects colour 1, 10 selects colour 2 and 11 selects colour 3. ovl_valid is 1 exactly when the select is nonzero.
- R6: The cursor is enabled only while bits 1:0 of the mode register (address 3) are nonzero. With both bits clear, every pixel is transparent.
- R7: Address 4 normally reads the status value and ignores writes. After bit 7 of address 0 is set and then 1 is written to address 1, address 4 reads and writes the extended register instead. Any other write to address 1, or clearing that bit, returns address 4 to status.
- R8: Bit 2 of the extended register selects a 64x64 window. When the bit is clear, the window is 32x32 and shows the top-left quadrant of the image.
- R9: A write to address 5 sets the colour index (bits 1:0) and restarts the byte phase. Writes to address 6 fill red, green and blue in that order, and the index advances after blue. Bytes written while the index is 0 are discarded. ovl_rgb shows the colour of the select and is 0 when ovl_valid is 0.
- R10: The outputs for a pixel appear on the clock edge after the pixel is presented, with the same one-cycle latency inside and outside the window. A pixel presented with pix_valid low gives transparent output.
- R11: A Y position of 1663 leaves every row below 1599 free of the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pix_valid | input | 1 | Pixel position is active |
| pix_x | input | 11 | Raster pixel column |
| pix_y | input | 11 | Raster pixel row |
| ovl_valid | output | 1 | Cursor covers the pixel with a visible colour |
| ovl_sel | output | 2 | Cursor colour select |
| ovl_rgb | output | 24 | Selected cursor colour, red in bits 23:16 |

## Verification
A wrong image pointer shows up at once as a shifted or mirrored shape. A marker pixel flanked by clear neighbours exposes bit order and byte stepping. The status readback shows where the pointer stands after half and all of the image. A wrong window offset or size turns the first edge pixel past the boundary visible one cycle after it is presented. A leaked extended-register write changes the window size and so shows in the next pixel sampled outside the 32x32 quadrant. A colour phase error shows up as swapped components on the first ovl_rgb sample for that select.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
   typedef enum logic [3:0] {
      RA_CTL0  = 4'd0,
      RA_INDEX = 4'd1,
      RA_IMAGE = 4'd2,
      RA_MODE  = 4'd3,
      RA_STAT  = 4'd4,
      RA_CIDX  = 4'd5,
      RA_CDATA = 4'd6,
      RA_XLO   = 4'd8,
      RA_XHI   = 4'd9,
      RA_YLO   = 4'd10,
      RA_YHI   = 4'd11
   } reg_addr_e;

   localparam int unsigned UNLOCK_BIT = 7;
   localparam int unsigned BIG_BIT    = 2;
   localparam int unsigned RGB_W      = 24;
   localparam int unsigned NCOL       = 4;
endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
   import hwcur_pkg::*;
#(
   parameter int unsigned POS_W = 12,
   parameter int unsigned PW    = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [3:0]             addr,
   input  logic [7:0]             wdata,
   output logic [7:0]             rdata,
   output logic                   cur_en,
   output logic                   big_win,
   output logic [POS_W-1:0]       pos_x,
   output logic [POS_W-1:0]       pos_y,
   output logic                   ram_we,
   output logic [PW-1:0]          ram_waddr,
   output logic [NCOL*RGB_W-1:0]  colours,
   output logic                   ext_sel,
   output logic [7:0]             xreg
);
   localparam int unsigned HIW = POS_W - 8;

   if (POS_W < 9 || POS_W > 16) begin : g_bad_pos
      $error("hwcur_regs: POS_W must be 9..16");
   end
   if (PW < 9 || PW > 16) begin : g_bad_pw
      $error("hwcur_regs: PW must be 9..16");
   end

   logic [7:0]     ctl0_q, mode_q, xreg_q, xlo_q, ylo_q;
   logic [HIW-1:0] xhi_q, yhi_q;
   logic [PW-1:0]  ptr_q;
   logic           ext_q;
   logic [1:0]     cidx_q, phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl0_q  <= '0;
         mode_q  <= '0;
         xreg_q  <= '0;
         xlo_q   <= '0;
         ylo_q   <= '0;
         xhi_q   <= '0;
         yhi_q   <= '0;
         ptr_q   <= '0;
         ext_q   <= 1'b0;
         cidx_q  <= '0;
         phase_q <= '0;
      end else if (wr) begin
         case (reg_addr_e'(addr))
            RA_CTL0: begin
               ctl0_q <= wdata;
               if (!wdata[UNLOCK_BIT]) ext_q <= 1'b0;
            end
            RA_INDEX: begin
               ptr_q <= PW'(wdata);
               ext_q <= ctl0_q[UNLOCK_BIT] && (wdata == 8'd1);
            end
            RA_IMAGE: ptr_q <= ptr_q + 1'b1;
            RA_MODE:  mode_q <= wdata;
            RA_STAT:  if (ext_q) xreg_q <= wdata;
            RA_CIDX: begin
               cidx_q  <= wdata[1:0];
               phase_q <= '0;
            end
            RA_CDATA: begin
               if (phase_q == 2'd2) begin
                  phase_q <= '0;
                  cidx_q  <= cidx_q + 1'b1;
               end else begin
                  phase_q <= phase_q + 1'b1;
               end
            end
            RA_XLO: xlo_q <= wdata;
            RA_XHI: xhi_q <= wdata[HIW-1:0];
            RA_YLO: ylo_q <= wdata;
            RA_YHI: yhi_q <= wdata[HIW-1:0];
            default: ;
         endcase
      end
   end

   assign colours[RGB_W-1:0] = '0;
   for (genvar c = 1; c < NCOL; c++) begin : g_col
      logic [RGB_W-1:0] c_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= '0;
         end else if (wr && addr == RA_CDATA && cidx_q == 2'(c)) begin
            case (phase_q)
               2'd0:    c_q[23:16] <= wdata;
               2'd1:    c_q[15:8]  <= wdata;
               default: c_q[7:0]   <= wdata;
            endcase
         end
      end
      assign colours[c*RGB_W +: RGB_W] = c_q;
   end

   always_comb begin
      case (reg_addr_e'(addr))
         RA_CTL0:  rdata = ctl0_q;
         RA_INDEX: rdata = ptr_q[7:0];
         RA_MODE:  rdata = mode_q;
         RA_STAT:  rdata = ext_q ? xreg_q : 8'(ptr_q >> 8);
         RA_CIDX:  rdata = {6'd0, cidx_q};
         RA_XLO:   rdata = xlo_q;
         RA_XHI:   rdata = 8'(xhi_q);
         RA_YLO:   rdata = ylo_q;
         RA_YHI:   rdata = 8'(yhi_q);
         default:  rdata = 8'd0;
      endcase
   end

   assign cur_en    = |mode_q[1:0];
   assign big_win   = xreg_q[BIG_BIT];
   assign pos_x     = {xhi_q, xlo_q};
   assign pos_y     = {yhi_q, ylo_q};
   assign ram_we    = wr && (addr == RA_IMAGE);
   assign ram_waddr = ptr_q;
   assign ext_sel   = ext_q;
   assign xreg      = xreg_q;
endmodule

// File: rtl/hwcur_ram.sv
module hwcur_ram #(
   parameter int unsigned PW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [PW-2:0] raddr,
   input  logic [2:0]    rbit,
   output logic [1:0]    plane_bits
);
   localparam int unsigned DEPTH = 1 << (PW - 1);

   for (genvar p = 0; p < 2; p++) begin : g_plane
      logic [7:0] mem [DEPTH];
      logic [7:0] rbyte;
      always_ff @(posedge clk) begin
         if (we && waddr[PW-1] == 1'(p)) mem[waddr[PW-2:0]] <= wdata;
      end
      assign rbyte = mem[raddr];
      // plane A (first half) is the high select bit
      assign plane_bits[1-p] = rbyte[3'd7 - rbit];
   end
endmodule

// File: rtl/hwcur_pix.sv
module hwcur_pix
   import hwcur_pkg::*;
#(
   parameter int unsigned CUR_DIM = 64,
   parameter int unsigned CW      = 11,
   parameter int unsigned POS_W   = 12,
   parameter int unsigned BIAS    = 64,
   parameter int unsigned PW      = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pix_valid,
   input  logic [CW-1:0]         pix_x,
   input  logic [CW-1:0]         pix_y,
   input  logic [POS_W-1:0]      pos_x,
   input  logic [POS_W-1:0]      pos_y,
   input  logic                  cur_en,
   input  logic                  big_win,
   input  logic [1:0]            plane_bits,
   input  logic [NCOL*RGB_W-1:0] colours,
   output logic [PW-2:0]         ram_raddr,
   output logic [2:0]            ram_rbit,
   output logic                  ovl_valid,
   output logic [1:0]            ovl_sel,
   output logic [RGB_W-1:0]      ovl_rgb
);
   localparam int unsigned LD = $clog2(CUR_DIM);
   localparam int unsigned DW = ((CW > POS_W) ? CW : POS_W) + 2;

   if ((1 << LD) != CUR_DIM || CUR_DIM < 16) begin : g_bad_dim
      $error("hwcur_pix: CUR_DIM must be a power of two >= 16");
   end
   if (2 * LD - 3 != PW - 1) begin : g_bad_pw
      $error("hwcur_pix: PW does not match CUR_DIM");
   end

   logic [DW-1:0] dx, dy, span;
   logic          hit;
   logic [1:0]    sel;

   assign dx   = DW'(pix_x) + DW'(BIAS) - DW'(pos_x);
   assign dy   = DW'(pix_y) + DW'(BIAS) - DW'(pos_y);
   assign span = big_win ? DW'(CUR_DIM) : DW'(CUR_DIM / 2);
   assign hit  = pix_valid && cur_en && (dx < span) && (dy < span);

   assign ram_raddr = {dy[LD-1:0], dx[LD-1:3]};
   assign ram_rbit  = dx[2:0];
   assign sel       = hit ? plane_bits : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovl_valid <= 1'b0;
         ovl_sel   <= '0;
         ovl_rgb   <= '0;
      end else begin
         ovl_valid <= |sel;
         ovl_sel   <= sel;
         ovl_rgb   <= colours[sel*RGB_W +: RGB_W];
      end
   end
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
   import hwcur_pkg::*;
#(
   parameter int unsigned CUR_DIM = 64,
   parameter int unsigned CW      = 11,
   parameter int unsigned POS_W   = 12,
   parameter int unsigned BIAS    = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        pix_valid,
   input  logic [CW-1:0] pix_x,
   input  logic [CW-1:0] pix_y,
   output logic        ovl_valid,
   output logic [1:0]  ovl_sel,
   output logic [23:0] ovl_rgb
);
   localparam int unsigned PTR_W = $clog2(2 * CUR_DIM * CUR_DIM / 8);

   logic                  cur_en, big_win, ram_we, ext_sel;
   logic [POS_W-1:0]      pos_x, pos_y;
   logic [PTR_W-1:0]      ram_waddr;
   logic [PTR_W-2:0]      ram_raddr;
   logic [2:0]            ram_rbit;
   logic [1:0]            plane_bits;
   logic [NCOL*RGB_W-1:0] colours;
   logic [7:0]            xreg;

   hwcur_regs #(.POS_W(POS_W), .PW(PTR_W)) u_regs (
      .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .cur_en, .big_win, .pos_x, .pos_y, .ram_we,
      .ram_waddr, .colours, .ext_sel, .xreg
   );

   hwcur_ram #(.PW(PTR_W)) u_ram (
      .clk, .we(ram_we), .waddr(ram_waddr), .wdata(reg_wdata),
      .raddr(ram_raddr), .rbit(ram_rbit), .plane_bits
   );

   hwcur_pix #(.CUR_DIM(CUR_DIM), .CW(CW), .POS_W(POS_W), .BIAS(BIAS), .PW(PTR_W)) u_pix (
      .clk, .rst_n, .pix_valid, .pix_x, .pix_y, .pos_x, .pos_y, .cur_en,
      .big_win, .plane_bits, .colours, .ram_raddr, .ram_rbit, .ovl_valid,
      .ovl_sel, .ovl_rgb
   );
endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk #(
   parameter int unsigned PW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [3:0]    reg_addr,
   input logic          pix_valid,
   input logic          cur_en,
   input logic          ext_sel,
   input logic [7:0]    xreg,
   input logic          ram_we,
   input logic [PW-1:0] ram_waddr,
   input logic          ovl_valid,
   input logic [1:0]    ovl_sel,
   input logic [23:0]   ovl_rgb
);
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> (ram_waddr == $past(ram_waddr) + 1'b1));

   assert_sel_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_valid == (ovl_sel != 2'b00));

   assert_mode_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_en |=> !ovl_valid);

   assert_locked_xreg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'd4 && !ext_sel) |=> $stable(xreg));

   assert_rgb_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_valid |-> (ovl_rgb == 24'd0));

   assert_blank_pixel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !ovl_valid);
endmodule

bind hwcur_overlay hwcur_overlay_chk #(.PW(PTR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .pix_valid(pix_valid), .cur_en(cur_en), .ext_sel(ext_sel), .xreg(xreg),
   .ram_we(ram_we), .ram_waddr(ram_waddr), .ovl_valid(ovl_valid),
   .ovl_sel(ovl_sel), .ovl_rgb(ovl_rgb)
);

// File: tb/hwcur_overlay_tb.sv
module hwcur_overlay_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        pix_valid = 1'b0;
   logic [10:0] pix_x = '0;
   logic [10:0] pix_y = '0;
   logic        ovl_valid;
   logic [1:0]  ovl_sel;
   logic [23:0] ovl_rgb;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   hwcur_overlay dut_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .pix_valid, .pix_x, .pix_y, .ovl_valid, .ovl_sel, .ovl_rgb
   );

   // {x[10:0], y[10:0], valid, sel[1:0]}; cursor origin (100,50), 64x64
   localparam logic [24:0] VEC [12] = '{
      {11'd100, 11'd50,  1'b0, 2'd0},
      {11'd132, 11'd50,  1'b1, 2'd2},
      {11'd100, 11'd82,  1'b1, 2'd1},
      {11'd132, 11'd82,  1'b1, 2'd3},
      {11'd163, 11'd113, 1'b1, 2'd3},
      {11'd164, 11'd113, 1'b0, 2'd0},
      {11'd163, 11'd114, 1'b0, 2'd0},
      {11'd99,  11'd82,  1'b0, 2'd0},
      {11'd109, 11'd51,  1'b1, 2'd2},
      {11'd108, 11'd51,  1'b0, 2'd0},
      {11'd110, 11'd51,  1'b0, 2'd0},
      {11'd100, 11'd49,  1'b0, 2'd0}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pix(input int x, input int y, input logic v);
      @(negedge clk);
      pix_x = 11'(x); pix_y = 11'(y); pix_valid = v;
      @(negedge clk);
      pix_valid = 1'b0;
   endtask

   function automatic logic [7:0] shape_byte(input int n);
      logic [7:0] b;
      if (n < 512) begin
         b = ((n % 8) >= 4) ? 8'hFF : 8'h00;
         if (n / 8 == 1 && n % 8 == 1) b = b | 8'h40;   // marker at row 1, col 9
      end else begin
         b = (((n - 512) / 8) >= 32) ? 8'hFF : 8'h00;
      end
      return b;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rreg(4'd0, rd); check("R1 ctl0", rd, 0);
      rreg(4'd3, rd); check("R1 mode", rd, 0);
      rreg(4'd4, rd); check("R1 status", rd, 0);
      rreg(4'd8, rd); check("R1 xlo", rd, 0);
      check("R1 ovl_valid", ovl_valid, 0);
      check("R1 ovl_rgb", ovl_rgb, 0);

      // R2: position registers, high bits masked
      wreg(4'd8, 8'hA4);
      wreg(4'd9, 8'hFF);
      rreg(4'd9, rd); check("R2 xhi mask", rd, 8'h0F);
      wreg(4'd9, 8'h00);
      wreg(4'd10, 8'h72);
      wreg(4'd11, 8'h00);
      rreg(4'd8, rd);  check("R2 xlo", rd, 8'hA4);
      rreg(4'd10, rd); check("R2 ylo", rd, 8'h72);

      // R4: image load with auto-increment and wrap
      wreg(4'd1, 8'h00);
      for (int n = 0; n < 512; n++) wreg(4'd2, shape_byte(n));
      rreg(4'd4, rd); check("R4 status half", rd, 2);
      for (int n = 512; n < 1024; n++) wreg(4'd2, shape_byte(n));
      rreg(4'd1, rd); check("R4 ptr wrap low", rd, 0);
      rreg(4'd4, rd); check("R4 ptr wrap high", rd, 0);

      // R8: small window by default
      wreg(4'd3, 8'h01);
      pix(109, 51, 1'b1); check("R8 small marker sel", ovl_sel, 2);
      pix(132, 50, 1'b1); check("R8 small outside", ovl_valid, 0);

      // R7: locked write ignored, unlock sequence opens extended register
      wreg(4'd4, 8'h04);
      pix(132, 50, 1'b1); check("R7 locked write ignored", ovl_valid, 0);
      wreg(4'd0, 8'h80);
      wreg(4'd1, 8'h01);
      wreg(4'd4, 8'h04);
      rreg(4'd4, rd); check("R7 xreg readback", rd, 8'h04);
      pix(132, 50, 1'b1); check("R8 big window", ovl_sel, 2);
      wreg(4'd1, 8'h00);
      rreg(4'd4, rd); check("R7 relock status", rd, 0);

      // R3 / R5: table walk
      for (int i = 0; i < 12; i++) begin
         pix(int'(VEC[i][24:14]), int'(VEC[i][13:3]), 1'b1);
         check($sformatf("R3 valid vec %0d", i), ovl_valid, VEC[i][2]);
         check($sformatf("R5 sel vec %0d", i), ovl_sel, VEC[i][1:0]);
      end

      // R6: mode bits
      wreg(4'd3, 8'h00);
      pix(132, 82, 1'b1); check("R6 disabled", ovl_valid, 0);
      wreg(4'd3, 8'h02);
      pix(132, 82, 1'b1); check("R6 mode 2 enabled", ovl_sel, 3);

      // R10: pix_valid low and latency
      pix(132, 82, 1'b0); check("R10 blank pixel", ovl_valid, 0);
      @(negedge clk);
      pix_x = 11'd132; pix_y = 11'd82; pix_valid = 1'b1;
      #1 check("R10 no early output", ovl_valid, 0);
      @(negedge clk);
      pix_valid = 1'b0;
      check("R10 one-cycle output", ovl_sel, 3);

      // R9: colours
      wreg(4'd5, 8'h01);
      wreg(4'd6, 8'h11); wreg(4'd6, 8'h22); wreg(4'd6, 8'h33);
      wreg(4'd6, 8'h44); wreg(4'd6, 8'h55); wreg(4'd6, 8'h66);
      wreg(4'd5, 8'h03);
      wreg(4'd6, 8'h77); wreg(4'd6, 8'h88); wreg(4'd6, 8'h99);
      wreg(4'd6, 8'hAA); wreg(4'd6, 8'hBB); wreg(4'd6, 8'hCC);
      rreg(4'd5, rd); check("R9 index advanced", rd, 1);
      pix(100, 82, 1'b1); check("R9 colour 1", ovl_rgb, 24'h112233);
      pix(132, 50, 1'b1); check("R9 colour 2", ovl_rgb, 24'h445566);
      pix(132, 82, 1'b1); check("R9 colour 3", ovl_rgb, 24'h778899);
      pix(100, 50, 1'b1); check("R9 transparent rgb", ovl_rgb, 0);

      // R3: bias origin at (64,64)
      wreg(4'd8, 8'd64); wreg(4'd9, 8'd0);
      wreg(4'd10, 8'd64); wreg(4'd11, 8'd0);
      pix(32, 32, 1'b1); check("R3 bias origin", ovl_sel, 3);
      pix(0, 32, 1'b1);  check("R3 left column", ovl_sel, 1);

      // R11: parking position
      wreg(4'd10, 8'h7F); wreg(4'd11, 8'h06);
      pix(32, 1598, 1'b1); check("R11 row 1598 clear", ovl_valid, 0);
      pix(32, 1631, 1'b1); check("R11 window below", ovl_sel, 3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule